// File: doc/BRIEF.md
# Four-Mode 32-Bit Barrel Shifter

This block is a combinational shifter. It takes a data word, a shift amount and a two-bit mode code, and returns the word moved by that amount. The mode picks one of four operations: a left shift that fills with zeros, a right shift that fills with zeros, a right shift that fills with the sign bit, or a left rotate. There are no clocks or registers, so the result is valid in the same cycle as its inputs. The block can sit in the execute path of a datapath.

The structure is logarithmic. There are log2(WIDTH) stages, and each stage moves the word by a fixed power of two when its bit of the amount is set. Right shifts use the same left-moving stages: the word is bit-reversed on the way in and again on the way out. The fill value each stage inserts is either zero, the sign bit, or the bits that fall off the top (for a rotate).

Top module: `barrel_shift4`

## Requirements
- R1: When mode = 0, dout equals din shifted left by amt, and the vacated low bits are zero.
- R2: When mode = 1, dout equals din shifted right by amt, and the vacated high bits are zero.
- R3: When mode = 2, dout equals din shifted right by amt, and the vacated high bits are copies of din bit 31.
- R4: When mode = 3, dout equals din rotated left by amt, so that bits leaving bit 31 come back in at bit 0.
- R5: When amt = 0, dout equals din in every mode.
- R6: For din = 0x80000001 and amt = 4, dout is 0x00000010 in mode 0, 0x08000000 in mode 1, 0xF8000000 in mode 2 and 0x00000018 in mode 3.
- R7: When din bit 31 is 0, mode 2 gives the same result as mode 1 for every amount.
- R8: A left rotate by 31 gives the same result as a right rotate by 1, that is {din[0], din[31:1]}.
- R9: dout depends only on the present inputs. It settles without a clock and holds no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 32 | Data word to be shifted |
| amt | input | 5 | Shift or rotate amount |
| mode | input | 2 | 0 shift left, 1 shift right logical, 2 shift right arithmetic, 3 rotate left |
| dout | output | 32 | Shifted result |

## Verification
The bound checker watches the ports whenever they change. It checks the following:
- a zero amount passes din through;
- a rotate keeps the number of set bits;
- a nonzero logical shift clears the bit at the far end;
- an arithmetic right shift copies the sign into bit 31.

Only the bench can show that every bit lands in the right place. It sweeps all amounts in all four modes over edge and pseudo-random words and compares against operator-built values. It also covers the worked example and the rotate identity, and checks that mode 2 matches mode 1 for non-negative words.

// File: rtl/bshift_pkg.sv
package bshift_pkg;
   typedef enum logic [1:0] {
      MODE_SLL  = 2'd0,
      MODE_SRL  = 2'd1,
      MODE_SRA  = 2'd2,
      MODE_ROTL = 2'd3
   } shift_mode_e;
endpackage

// File: rtl/bshift_bitrev.sv
module bshift_bitrev #(
   parameter int W = 32
) (
   input  logic         en,
   input  logic [W-1:0] in_word,
   output logic [W-1:0] out_word
);
   logic [W-1:0] flipped;

   for (genvar i = 0; i < W; i++) begin : g_flip
      assign flipped[i] = in_word[W-1-i];
   end

   assign out_word = en ? flipped : in_word;
endmodule

// File: rtl/bshift_stage.sv
module bshift_stage #(
   parameter int W = 32,
   parameter int D = 1
) (
   input  logic         en,
   input  logic         rot,
   input  logic         fill,
   input  logic [W-1:0] in_word,
   output logic [W-1:0] out_word
);
   initial begin
      if (D < 1 || D >= W) $error("bshift_stage: distance out of range");
   end

   logic [D-1:0] low_in;

   always_comb begin
      if (rot) low_in = in_word[W-1:W-D];
      else     low_in = {D{fill}};
   end

   assign out_word = en ? {in_word[W-1-D:0], low_in} : in_word;
endmodule

// File: rtl/barrel_shift4.sv
module barrel_shift4
   import bshift_pkg::*;
#(
   parameter int WIDTH = 32,
   localparam int SHW = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] din,
   input  logic [SHW-1:0]   amt,
   input  logic [1:0]       mode,
   output logic [WIDTH-1:0] dout
);
   initial begin
      if (WIDTH < 2) $error("barrel_shift4: WIDTH must be at least 2");
      if ((1 << SHW) != WIDTH) $error("barrel_shift4: WIDTH must be a power of two");
   end

   logic is_right;
   logic is_rot;
   logic fill_bit;

   always_comb begin
      is_right = (mode == MODE_SRL) || (mode == MODE_SRA);
      is_rot   = (mode == MODE_ROTL);
      fill_bit = (mode == MODE_SRA) && din[WIDTH-1];
   end

   logic [SHW:0][WIDTH-1:0] stg;
   logic [WIDTH-1:0]        pre_word;
   logic [WIDTH-1:0]        post_word;

   bshift_bitrev #(.W(WIDTH)) u_rev_in (
      .en(is_right), .in_word(din), .out_word(pre_word)
   );

   assign stg[0] = pre_word;

   for (genvar k = 0; k < SHW; k++) begin : g_stage
      bshift_stage #(.W(WIDTH), .D(1 << k)) u_stage (
         .en      (amt[k]),
         .rot     (is_rot),
         .fill    (fill_bit),
         .in_word (stg[k]),
         .out_word(stg[k+1])
      );
   end

   bshift_bitrev #(.W(WIDTH)) u_rev_out (
      .en(is_right), .in_word(stg[SHW]), .out_word(post_word)
   );

   assign dout = post_word;
endmodule

// File: rtl/bshift_chk.sv
module bshift_chk #(
   parameter int WIDTH = 32,
   localparam int SHW = $clog2(WIDTH)
) (
   input logic [WIDTH-1:0] din,
   input logic [SHW-1:0]   amt,
   input logic [1:0]       mode,
   input logic [WIDTH-1:0] dout
);
   always_comb begin
      // R5
      zero_amt_chk: assert (amt != '0 || dout == din);
      // R4
      rot_ones_chk: assert (mode != 2'd3 || $countones(dout) == $countones(din));
      // R1
      sll_lsb_chk: assert (mode != 2'd0 || amt == '0 || dout[0] == 1'b0);
      // R2
      srl_msb_chk: assert (mode != 2'd1 || amt == '0 || dout[WIDTH-1] == 1'b0);
      // R3
      sra_sign_chk: assert (mode != 2'd2 || dout[WIDTH-1] == din[WIDTH-1]);
   end
endmodule

bind barrel_shift4 bshift_chk #(.WIDTH(WIDTH)) u_chk (
   .din(din), .amt(amt), .mode(mode), .dout(dout)
);

// File: tb/sim_barrel_shift4.sv
module sim_barrel_shift4;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic [31:0] din;
   logic [4:0]  amt;
   logic [1:0]  mode;
   logic [31:0] dout;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   barrel_shift4 u0 (.din(din), .amt(amt), .mode(mode), .dout(dout));

   function automatic logic [31:0] model(logic [31:0] x, int c, int m);
      case (m)
         0: return x << c;
         1: return x >> c;
         2: return 32'($signed(x) >>> c);
         default: return (c == 0) ? x : ((x << c) | (x >> (32 - c)));
      endcase
   endfunction

   function automatic string mtag(int m);
      case (m)
         0: return "R1";
         1: return "R2";
         2: return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic apply(logic [31:0] x, int c, int m);
      @(negedge clk);
      din = x; amt = 5'(c); mode = 2'(m);
      #2;
   endtask

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: din=%h amt=%0d mode=%0d got=%h exp=%h", tag, din, amt, mode, got, exp);
      end
   endtask

   initial begin
      logic [31:0] pats [8];
      logic [31:0] lcg;
      logic [31:0] lsr_val;
      din = '0; amt = '0; mode = '0;
      pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
      pats[2] = 32'h8000_0000; pats[3] = 32'h0000_0001;
      lcg = 32'h1234_5678;
      for (int i = 4; i < 8; i++) begin
         lcg = lcg * 32'd1664525 + 32'd1013904223;
         pats[i] = lcg;
      end

      // R9: output follows inputs with no clock edge in between
      din = 32'hA5A5_0F0F; amt = 5'd8; mode = 2'd0;
      #1;
      check("R9", dout, 32'hA50F_0F00);
      din = 32'h0000_00F0; #1;
      check("R9", dout, 32'h0000_F000);

      // R6 worked example
      for (int m = 0; m < 4; m++) begin
         logic [31:0] e;
         apply(32'h8000_0001, 4, m);
         case (m)
            0: e = 32'h0000_0010;
            1: e = 32'h0800_0000;
            2: e = 32'hF800_0000;
            default: e = 32'h0000_0018;
         endcase
         check("R6", dout, e);
      end

      // R1..R4 full sweep; R5 at amount zero
      for (int p = 0; p < 8; p++)
         for (int m = 0; m < 4; m++)
            for (int c = 0; c < 32; c++) begin
               apply(pats[p], c, m);
               check(mtag(m), dout, model(pats[p], c, m));
               if (c == 0) check("R5", dout, pats[p]);
            end

      // R7: arithmetic equals logical for non-negative words
      for (int p = 0; p < 8; p++)
         for (int c = 0; c < 32; c++) begin
            logic [31:0] x;
            x = pats[p] & 32'h7FFF_FFFF;
            apply(x, c, 1);
            lsr_val = dout;
            apply(x, c, 2);
            check("R7", dout, lsr_val);
         end

      // R8: rotate left 31 equals rotate right 1
      for (int p = 0; p < 8; p++) begin
         apply(pats[p], 31, 3);
         check("R8", dout, {pats[p][0], pats[p][31:1]});
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got=timeout exp=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule